// File: doc/BRIEF.md
# Seven-Bit Packed Sample Frame Encoder

This block turns one set of six 10-bit channel samples and one 8-bit auxiliary value into an 11-byte frame for a byte-oriented serial link. Each byte carries seven payload bits. Its most significant bit is a marker that is set only on the closing byte of a frame, so a receiver that joins the stream mid-frame can find the next frame boundary from the data alone. Each sample is split into a 7-bit low part and a 3-bit high part. The high parts of a channel pair share one byte. A 6-bit frame counter is placed in the first byte, which lets lost frames be detected.

The producer offers a parallel sample set with a one-cycle start strobe. The encoder captures the inputs and then presents the frame one byte at a time on a valid/ready stream. A strobe that arrives while a frame is still being sent has no effect.

Top module: `frame7_packer`

## Requirements
- R1: After reset, outValid is 0 and the first frame sent carries counter value 0.
- R2: A startStb seen while idle captures sampIn and auxIn, and outValid is 1 in the next cycle with the first byte on outData. Input changes after that capture do not alter the frame. Channel c occupies sampIn[10*c+9 : 10*c].
- R3: Byte 1 holds the frame counter in bits 6..1 and aux bit 7 in bit 0.
- R4: Byte 2 holds aux bits 6..0 in bits 6..0.
- R5: For pair p (channels 2p and 2p+1), byte 3+3p carries bits 6..0 of channel 2p, and byte 4+3p carries bits 6..0 of channel 2p+1. Pairs are sent in ascending order.
- R6: Byte 5+3p carries bits 9..7 of channel 2p in bits 6..4 and bits 9..7 of channel 2p+1 in bits 2..0. Bit 3 is 0.
- R7: Bit 7 is 0 in bytes 1 to 10 and 1 in byte 11.
- R8: The frame counter rises by one after each completed frame and wraps from 63 to 0.
- R9: While outValid is 1 and outReady is 0, outData and outValid hold.
- R10: A startStb while a frame is in progress is ignored. The frame being sent, the later counter values and the idle state after the frame are all unchanged by it.
- R11: A frame ends after exactly 11 accepted bytes, and outValid is then 0 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | One-cycle request to encode the inputs |
| sampIn | input | 60 | Six packed 10-bit channel samples |
| auxIn | input | 8 | Auxiliary byte |
| outData | output | 8 | Current frame byte |
| outValid | output | 1 | outData holds a frame byte |
| outReady | input | 1 | Consumer accepts the byte in this cycle |

## Verification
The assertions assume that the consumer may stall at any time, and that the producer may strobe at any time, including in the middle of a frame. They do not assume that outReady is steady. The stimulus exercises both of these: on alternate frames the consumer withholds ready on a fixed cadence, and on some frames a stray strobe with different data is injected in the middle of the frame. The sample values cover all-zero, all-ones, alternating bit patterns and a pseudo-random sequence, over enough frames for the counter to wrap.

// File: rtl/frame7_pkg.sv
package frame7_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;    // capture inputs, start a frame
    logic finish;  // last byte accepted this cycle
  } ctlStb_t;
endpackage

// File: rtl/frame7_ctrl.sv
module frame7_ctrl
  import frame7_pkg::*;
#(
  parameter int FRAME_LEN = 11,
  localparam int IDX_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic             outReady,
  output logic             outValid,
  output logic [IDX_W-1:0] byteIdx,
  output ctlStb_t          ctl
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic             sending;
  logic [IDX_W-1:0] idx;
  logic             advance;

  always_comb begin
    advance    = sending && outReady;
    ctl.load   = startStb && !sending;
    ctl.finish = advance && (idx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sending <= 1'b0;
      idx     <= '0;
    end else if (ctl.load) begin
      sending <= 1'b1;
      idx     <= '0;
    end else if (ctl.finish) begin
      sending <= 1'b0;
      idx     <= '0;
    end else if (advance) begin
      idx <= idx + 1'b1;
    end
  end

  assign outValid = sending;
  assign byteIdx  = idx;
endmodule

// File: rtl/frame7_dp.sv
module frame7_dp
  import frame7_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int SAMP_W    = 10,
  parameter int LOW_W     = 7,
  parameter int AUX_W     = 8,
  parameter int CNT_W     = 6,
  parameter int FRAME_LEN = 11,
  localparam int IDX_W    = $clog2(FRAME_LEN),
  localparam int BYTE_W   = LOW_W + 1,
  localparam int HI_W     = SAMP_W - LOW_W,
  localparam int PAD_W    = LOW_W - 2 * HI_W,
  localparam int NUM_PAIRS = NUM_CH / 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStb_t                  ctl,
  input  logic [IDX_W-1:0]         byteIdx,
  input  logic [NUM_CH*SAMP_W-1:0] sampIn,
  input  logic [AUX_W-1:0]         auxIn,
  output logic [BYTE_W-1:0]        outData
);
  logic [SAMP_W-1:0] sampReg [NUM_CH];
  logic [AUX_W-1:0]  auxReg;
  logic [CNT_W-1:0]  pktCnt;
  logic [BYTE_W-1:0] frameBytes [FRAME_LEN];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      auxReg <= '0;
      pktCnt <= '0;
    end else begin
      if (ctl.load)   auxReg <= auxIn;
      if (ctl.finish) pktCnt <= pktCnt + 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cap
    always_ff @(posedge clk) begin
      if (!rstN)         sampReg[c] <= '0;
      else if (ctl.load) sampReg[c] <= sampIn[c*SAMP_W +: SAMP_W];
    end
  end

  // Header bytes
  assign frameBytes[0] = {1'b0, pktCnt, auxReg[AUX_W-1]};
  assign frameBytes[1] = {1'b0, auxReg[AUX_W-2:0]};

  // Three bytes per channel pair; the final high byte carries the end marker
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int BASE = 2 + 3 * p;
    localparam logic MARK = (p == NUM_PAIRS - 1);
    assign frameBytes[BASE]     = {1'b0, sampReg[2*p][LOW_W-1:0]};
    assign frameBytes[BASE + 1] = {1'b0, sampReg[2*p+1][LOW_W-1:0]};
    assign frameBytes[BASE + 2] = {MARK, sampReg[2*p][SAMP_W-1:LOW_W],
                                   {PAD_W{1'b0}}, sampReg[2*p+1][SAMP_W-1:LOW_W]};
  end

  always_comb begin
    outData = '0;
    for (int k = 0; k < FRAME_LEN; k++) begin
      if (byteIdx == IDX_W'(k)) outData = frameBytes[k];
    end
  end
endmodule

// File: rtl/frame7_packer.sv
module frame7_packer
  import frame7_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int SAMP_W = 10,
  parameter int LOW_W  = 7,
  parameter int AUX_W  = 8,
  parameter int CNT_W  = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startStb,
  input  logic [NUM_CH*SAMP_W-1:0] sampIn,
  input  logic [AUX_W-1:0]         auxIn,
  output logic [LOW_W:0]           outData,
  output logic                     outValid,
  input  logic                     outReady
);
  localparam int FRAME_LEN = 2 + 3 * (NUM_CH / 2);
  localparam int IDX_W     = $clog2(FRAME_LEN);

  ctlStb_t          ctl;
  logic [IDX_W-1:0] byteIdx;

  frame7_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startStb (startStb),
    .outReady (outReady),
    .outValid (outValid),
    .byteIdx  (byteIdx),
    .ctl      (ctl)
  );

  frame7_dp #(
    .NUM_CH(NUM_CH), .SAMP_W(SAMP_W), .LOW_W(LOW_W),
    .AUX_W(AUX_W), .CNT_W(CNT_W), .FRAME_LEN(FRAME_LEN)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .byteIdx (byteIdx),
    .sampIn  (sampIn),
    .auxIn   (auxIn),
    .outData (outData)
  );
endmodule

// File: rtl/frame7_checker.sv
module frame7_checker #(
  parameter int FRAME_LEN = 11,
  parameter int BYTE_W    = 8,
  localparam int CW       = $clog2(FRAME_LEN + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              startStb,
  input logic              outValid,
  input logic              outReady,
  input logic [BYTE_W-1:0] outData
);
  logic [CW-1:0] seen;  // bytes accepted so far in the current frame

  always_ff @(posedge clk) begin
    if (!rstN) seen <= '0;
    else if (outValid && outReady) seen <= outData[BYTE_W-1] ? '0 : seen + 1'b1;
  end

  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !outValid && startStb |=> outValid);

  p_end_drop_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outData[BYTE_W-1] |=> !outValid);

  p_len_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> seen < CW'(FRAME_LEN));

  p_mark_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outData[BYTE_W-1] == (seen == CW'(FRAME_LEN - 1))));

  p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outData[BYTE_W-1] |-> !outData[3]);

  p_idle_reset_r1: assert property (@(posedge clk)
    $past(!rstN) && !rstN |-> !outValid);
endmodule

bind frame7_packer frame7_checker #(.FRAME_LEN(FRAME_LEN), .BYTE_W(LOW_W + 1)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startStb (startStb),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData)
);

// File: tb/sim_frame7_packer.sv
`timescale 1ns/100ps
module sim_frame7_packer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStb = 1'b0;
  logic [59:0] sampIn = '0;
  logic [7:0]  auxIn = '0;
  logic [7:0]  outData;
  logic        outValid;
  logic        outReady = 1'b0;

  int total = 0;
  int bad = 0;
  logic [9:0] curSamp [6];
  logic [7:0] curAux;
  logic [15:0] lfsr = 16'hACE1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  frame7_packer u0 (
    .clk(clk), .rstN(rstN), .startStb(startStb), .sampIn(sampIn),
    .auxIn(auxIn), .outData(outData), .outValid(outValid), .outReady(outReady)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stepLfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Expected byte k of a frame from the frame layout rules
  function automatic logic [7:0] expByte(input int k, input int cnt);
    int p, pos;
    logic [5:0] c6;
    c6 = cnt[5:0];
    if (k == 0) return {1'b0, c6, curAux[7]};              // R3
    if (k == 1) return {1'b0, curAux[6:0]};                // R4
    p = (k - 2) / 3;
    pos = (k - 2) % 3;
    if (pos == 0) return {1'b0, curSamp[2*p][6:0]};        // R5
    if (pos == 1) return {1'b0, curSamp[2*p+1][6:0]};      // R5
    return {(p == 2), curSamp[2*p][9:7], 1'b0, curSamp[2*p+1][9:7]};  // R6, R7
  endfunction

  function automatic string reqOf(input int k);
    if (k == 0) return "R3";
    if (k == 1) return "R4";
    if ((k - 2) % 3 == 2) return "R6_R7";
    return "R5";
  endfunction

  task automatic startFrame();
    logic [59:0] flat;
    for (int c = 0; c < 6; c++) flat[c*10 +: 10] = curSamp[c];
    @(negedge clk);
    sampIn = flat;
    auxIn = curAux;
    startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
    sampIn = ~flat;      // later changes must not leak in (R2)
    auxIn = ~curAux;
    check("R2 valid after start", outValid, 1);
  endtask

  task automatic getFrame(input int cnt, input bit stall, input bit poke);
    int idx = 0;
    int cyc = 0;
    bit poked = 0;
    while (idx < 11 && cyc < 200) begin
      @(negedge clk);
      startStb = 1'b0;
      cyc++;
      outReady = stall ? (cyc % 3 != 0) : 1'b1;
      if (poke && !poked && idx == 4) begin
        startStb = 1'b1;        // stray strobe mid-frame (R10)
        sampIn = {60{1'b1}} ^ sampIn;
        auxIn = 8'h3C;
        poked = 1;
      end
      check("R11 valid during frame", outValid, 1);
      if (outReady) begin
        check(reqOf(idx), outData, expByte(idx, cnt));
        idx++;
      end else begin
        check("R9 held byte", outData, expByte(idx, cnt));
      end
    end
    @(negedge clk);
    startStb = 1'b0;
    outReady = 1'b0;
    check("R11 idle after 11 bytes", outValid, 0);
    @(negedge clk);
    check(poke ? "R10 no restart" : "R11 stays idle", outValid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset idle", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", outValid, 0);
    for (int f = 0; f < 70; f++) begin
      for (int c = 0; c < 6; c++) begin
        case (f)
          0: curSamp[c] = 10'h000;
          1: curSamp[c] = 10'h3FF;
          2: curSamp[c] = (c % 2) ? 10'h2AA : 10'h155;
          3: curSamp[c] = 10'h001 << c;
          default: begin
            lfsr = stepLfsr(lfsr);
            curSamp[c] = lfsr[9:0];
          end
        endcase
      end
      case (f)
        0: curAux = 8'h00;
        1: curAux = 8'hFF;
        2: curAux = 8'h80;
        3: curAux = 8'h7F;
        default: begin
          lfsr = stepLfsr(lfsr);
          curAux = lfsr[7:0];
        end
      endcase
      // counter value f mod 64 checks R1 (first is 0) and R8 (wrap)
      startFrame();
      getFrame(f % 64, f % 2 == 1, f % 5 == 3);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule